// File: doc/BRIEF.md
# Sequencer Return and Loop Context Stacks

This block keeps the nesting context of a small program sequencer in two last-in, first-out stores. The return store is 16 entries of 14 bits each. It holds subroutine return addresses, interrupted addresses and top-of-loop addresses. The loop store is 4 entries of 18 bits each. Every loop entry carries a 14-bit end-of-loop address and a 4-bit exit condition code.

The sequencer issues one command per cycle through `op_valid` and `op_code`. Some commands act on both stores at once. A loop start pushes onto both stores, and a loop exit pops from both. The remaining commands act on a single store: call, return, interrupt entry, manual push and pop of the return store, and a manual loop pop.

There is no data stream here, so there is no valid/ready pair. A command is a single-cycle strobe that is never back-pressured. The sequencer reads the full and empty flags to decide whether a command is safe to issue. The top-of-store outputs and the flags change one clock edge after the command that changed them.

Top module: `seq_ctx_stacks`

## Requirements
- R1: After reset, both stores are empty. `pc_empty` and `loop_empty` are 1, the full and overflow flags are 0, and all top outputs are zero.
- R2: Op code 1 (call) pushes `pc_in + 1`, truncated to 14 bits, onto the return store. Op code 3 (interrupt entry) pushes `pc_in` unchanged.
- R3: Op code 2 (return) and op code 7 (manual pop) each remove the top entry of the return store. On the next cycle, `pc_top` shows the entry that lay beneath it.
- R4: Op code 6 (manual push) pushes `man_data`. On the cycle after any command, `pc_top` shows the most recently pushed entry that is still held, in last-in, first-out order.
- R5: The return store holds 16 entries, and `pc_full` is 1 while it holds 16. A push to a full return store is dropped and sets `pc_ovf`. `pc_ovf` stays set until reset.
- R6: Op code 4 (loop start) does two things in the same cycle. It pushes `{loop_end_in, loop_cond_in}` onto the loop store, and it pushes `pc_in + 1` onto the return store.
- R7: Op code 5 (loop exit) pops both the loop store and the return store in the same cycle.
- R8: Op code 8 (manual loop pop) pops only the loop store and leaves the return store unchanged.
- R9: The loop store holds 4 entries, and `loop_full` is 1 while it holds 4. A loop push to a full loop store is dropped and sets the sticky `loop_ovf`. The return-store half of that loop start still takes effect if the return store has room.
- R10: A pop from an empty store leaves that store empty, keeps its top output at zero and leaves its overflow flag unchanged.
- R11: A cycle with `op_valid` low, or with op code 0 or 9 to 15, changes neither store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command strobe for this cycle |
| op_code | input | 4 | Command code (see requirements) |
| pc_in | input | 14 | Current program address |
| man_data | input | 14 | Value for a manual return-store push |
| loop_end_in | input | 14 | End-of-loop address for a loop start |
| loop_cond_in | input | 4 | Exit condition code for a loop start |
| pc_top | output | 14 | Top of return store, zero when empty |
| pc_full | output | 1 | Return store holds 16 entries |
| pc_empty | output | 1 | Return store holds no entry |
| pc_ovf | output | 1 | Sticky: a return-store push was dropped |
| loop_end_top | output | 14 | End address of top loop entry, zero when empty |
| loop_cond_top | output | 4 | Condition code of top loop entry, zero when empty |
| loop_full | output | 1 | Loop store holds 4 entries |
| loop_empty | output | 1 | Loop store holds no entry |
| loop_ovf | output | 1 | Sticky: a loop push was dropped |

## Verification
The bench first runs mixed sequences of call, interrupt entry, manual push and pop, and return. These show whether each push source is chosen correctly, including the address wrap at 0x3FFF. It then fills the return store past its depth and drains it, which checks last-in, first-out order, the point where pushes are dropped and the sticky overflow flag. Nested loop starts, loop exits and manual loop pops come next; they show whether the two stores move together or alone as each command requires. Finally, pops on empty stores and idle or unused op codes confirm that nothing moves when it must not.

// File: rtl/seq_stk_pkg.sv
package seq_stk_pkg;
  localparam int ADDR_W   = 14;
  localparam int COND_W   = 4;
  localparam int RET_DEPTH  = 16;
  localparam int LOOP_DEPTH = 4;
  localparam int LOOP_W   = ADDR_W + COND_W;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_CALL       = 4'd1,
    OP_RETURN     = 4'd2,
    OP_IRQ        = 4'd3,
    OP_LOOP_START = 4'd4,
    OP_LOOP_EXIT  = 4'd5,
    OP_RET_PUSH   = 4'd6,
    OP_RET_POP    = 4'd7,
    OP_LOOP_POP   = 4'd8
  } seq_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] end_addr;
    logic [COND_W-1:0] cond;
  } loop_ent_t;
endpackage

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int W     = 14,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign wr_idx = AW'(cnt);
  assign rd_idx = AW'(cnt - CW'(1));
  assign top    = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  // R4
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (top == $past(wdata)));
  // R4
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (cnt == $past(cnt) + CW'(1)));
  // R5
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (ovf && full));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (empty && top == '0 && $stable(ovf)));
endmodule

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import seq_stk_pkg::*;
(
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] man_data,
  output logic              ret_push,
  output logic              ret_pop,
  output logic [ADDR_W-1:0] ret_wdata,
  output logic              loop_push,
  output logic              loop_pop
);
  logic [ADDR_W-1:0] next_pc;
  assign next_pc = pc_in + ADDR_W'(1);

  always_comb begin
    ret_push  = 1'b0;
    ret_pop   = 1'b0;
    ret_wdata = next_pc;
    loop_push = 1'b0;
    loop_pop  = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_CALL:       ret_push = 1'b1;
        OP_IRQ:        begin ret_push = 1'b1; ret_wdata = pc_in; end
        OP_RETURN,
        OP_RET_POP:    ret_pop = 1'b1;
        OP_RET_PUSH:   begin ret_push = 1'b1; ret_wdata = man_data; end
        OP_LOOP_START: begin ret_push = 1'b1; loop_push = 1'b1; end
        OP_LOOP_EXIT:  begin ret_pop = 1'b1; loop_pop = 1'b1; end
        OP_LOOP_POP:   loop_pop = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/seq_ctx_stacks.sv
module seq_ctx_stacks
  import seq_stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] man_data,
  input  logic [ADDR_W-1:0] loop_end_in,
  input  logic [COND_W-1:0] loop_cond_in,
  output logic [ADDR_W-1:0] pc_top,
  output logic              pc_full,
  output logic              pc_empty,
  output logic              pc_ovf,
  output logic [ADDR_W-1:0] loop_end_top,
  output logic [COND_W-1:0] loop_cond_top,
  output logic              loop_full,
  output logic              loop_empty,
  output logic              loop_ovf
);
  logic              ret_push, ret_pop, loop_push, loop_pop;
  logic [ADDR_W-1:0] ret_wdata;
  loop_ent_t         loop_wdata, loop_rdata;

  seq_cmd_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .pc_in    (pc_in),
    .man_data (man_data),
    .ret_push (ret_push),
    .ret_pop  (ret_pop),
    .ret_wdata(ret_wdata),
    .loop_push(loop_push),
    .loop_pop (loop_pop)
  );

  lifo_store #(.W(ADDR_W), .DEPTH(RET_DEPTH)) u_ret (
    .clk  (clk),
    .rst_n(rst_n),
    .push (ret_push),
    .pop  (ret_pop),
    .wdata(ret_wdata),
    .top  (pc_top),
    .full (pc_full),
    .empty(pc_empty),
    .ovf  (pc_ovf)
  );

  assign loop_wdata = '{end_addr: loop_end_in, cond: loop_cond_in};

  lifo_store #(.W(LOOP_W), .DEPTH(LOOP_DEPTH)) u_loop (
    .clk  (clk),
    .rst_n(rst_n),
    .push (loop_push),
    .pop  (loop_pop),
    .wdata(loop_wdata),
    .top  (loop_rdata),
    .full (loop_full),
    .empty(loop_empty),
    .ovf  (loop_ovf)
  );

  assign loop_end_top  = loop_rdata.end_addr;
  assign loop_cond_top = loop_rdata.cond;

  // R6
  loop_start_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOOP_START && !pc_full)
      |=> (pc_top == $past(pc_in) + ADDR_W'(1)));
  // R6
  loop_start_ent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOOP_START && !loop_full)
      |=> (loop_end_top == $past(loop_end_in) && loop_cond_top == $past(loop_cond_in)));
  // R8
  loop_pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOOP_POP) |=> ($stable(pc_top) && $stable(pc_empty)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(pc_top) && $stable(pc_empty) && $stable(loop_end_top)
                   && $stable(loop_cond_top) && $stable(loop_empty)));
endmodule

// File: tb/seq_ctx_stacks_test.sv
module seq_ctx_stacks_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [13:0] pc_in = '0, man_data = '0, loop_end_in = '0;
  logic [3:0]  loop_cond_in = '0;
  logic [13:0] pc_top, loop_end_top;
  logic [3:0]  loop_cond_top;
  logic        pc_full, pc_empty, pc_ovf, loop_full, loop_empty, loop_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [13:0] pt; logic pf, pe, po;
    logic [13:0] le; logic [3:0] lc; logic lf, lem, lo;
    string tag;
  } exp_t;

  exp_t sb[$];
  logic [13:0] ret_m[$];
  logic [17:0] loop_m[$];
  bit ret_ovf_m = 0, loop_ovf_m = 0;

  seq_ctx_stacks uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model_state(string tag);
    exp_t e;
    e.pt  = ret_m.size() ? ret_m[$] : 14'd0;
    e.pf  = (ret_m.size() == 16);
    e.pe  = (ret_m.size() == 0);
    e.po  = ret_ovf_m;
    e.le  = loop_m.size() ? loop_m[$][17:4] : 14'd0;
    e.lc  = loop_m.size() ? loop_m[$][3:0] : 4'd0;
    e.lf  = (loop_m.size() == 4);
    e.lem = (loop_m.size() == 0);
    e.lo  = loop_ovf_m;
    e.tag = tag;
    return e;
  endfunction

  function automatic void m_ret_push(logic [13:0] v);
    if (ret_m.size() == 16) ret_ovf_m = 1; else ret_m.push_back(v);
  endfunction
  function automatic void m_ret_pop();
    if (ret_m.size() != 0) void'(ret_m.pop_back());
  endfunction
  function automatic void m_loop_push(logic [17:0] v);
    if (loop_m.size() == 4) loop_ovf_m = 1; else loop_m.push_back(v);
  endfunction
  function automatic void m_loop_pop();
    if (loop_m.size() != 0) void'(loop_m.pop_back());
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (pc_top !== e.pt || pc_full !== e.pf || pc_empty !== e.pe || pc_ovf !== e.po ||
        loop_end_top !== e.le || loop_cond_top !== e.lc || loop_full !== e.lf ||
        loop_empty !== e.lem || loop_ovf !== e.lo) begin
      fails++;
      $display("FAIL %s: actual pc_top=%h f/e/o=%b%b%b loop=%h/%h f/e/o=%b%b%b expected pc_top=%h f/e/o=%b%b%b loop=%h/%h f/e/o=%b%b%b",
        e.tag, pc_top, pc_full, pc_empty, pc_ovf, loop_end_top, loop_cond_top,
        loop_full, loop_empty, loop_ovf, e.pt, e.pf, e.pe, e.po, e.le, e.lc, e.lf, e.lem, e.lo);
    end
  endtask

  // driver: one command per cycle, expected state queued for the monitor
  task automatic drive(bit v, logic [3:0] op, logic [13:0] pc, logic [13:0] md,
                       logic [13:0] le, logic [3:0] lc, string tag);
    @(negedge clk);
    op_valid = v; op_code = op; pc_in = pc; man_data = md;
    loop_end_in = le; loop_cond_in = lc;
    if (v) begin
      case (op)
        4'd1: m_ret_push(pc + 14'd1);
        4'd2, 4'd7: m_ret_pop();
        4'd3: m_ret_push(pc);
        4'd4: begin m_ret_push(pc + 14'd1); m_loop_push({le, lc}); end
        4'd5: begin m_ret_pop(); m_loop_pop(); end
        4'd6: m_ret_push(md);
        4'd8: m_loop_pop();
        default: ;
      endcase
    end
    sb.push_back(model_state(tag));
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() != 0) compare(sb.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(model_state("R1 reset state"));

    // R11: idle and unused codes
    drive(0, 4'd1, 14'h0100, 0, 0, 0, "R11 valid low");
    drive(1, 4'd0, 14'h0100, 0, 0, 0, "R11 op 0");
    drive(1, 4'd9, 14'h0100, 0, 0, 0, "R11 op 9");
    drive(1, 4'd15, 14'h0100, 0, 0, 0, "R11 op 15");
    // R2: push sources
    drive(1, 4'd1, 14'h0100, 0, 0, 0, "R2 call pushes pc+1");
    drive(1, 4'd3, 14'h0200, 0, 0, 0, "R2 irq pushes pc");
    drive(1, 4'd1, 14'h3FFF, 0, 0, 0, "R2 call wraps");
    // R3, R4
    drive(1, 4'd2, 0, 0, 0, 0, "R3 return");
    drive(1, 4'd6, 0, 14'h1234, 0, 0, "R4 manual push");
    drive(0, 4'd0, 0, 0, 0, 0, "R11 idle after push");
    drive(1, 4'd7, 0, 0, 0, 0, "R3 manual pop");
    drive(1, 4'd2, 0, 0, 0, 0, "R3 return");
    drive(1, 4'd2, 0, 0, 0, 0, "R3 return to empty");
    drive(1, 4'd2, 0, 0, 0, 0, "R10 return on empty");
    // R5: fill and overflow
    for (int i = 0; i < 16; i++)
      drive(1, 4'd6, 0, 14'(i * 3 + 5), 0, 0, "R5 fill");
    drive(1, 4'd6, 0, 14'h2AAA, 0, 0, "R5 push when full dropped");
    drive(1, 4'd1, 14'h0011, 0, 0, 0, "R5 call when full dropped");
    for (int i = 0; i < 16; i++)
      drive(1, 4'd7, 0, 0, 0, 0, "R4 drain order");
    drive(1, 4'd7, 0, 0, 0, 0, "R10 pop empty, R5 ovf kept");
    // R6..R9 loops
    drive(1, 4'd4, 14'h0040, 0, 14'h0050, 4'hA, "R6 loop start");
    drive(1, 4'd4, 14'h0045, 0, 14'h004A, 4'h3, "R6 nested loop start");
    drive(1, 4'd5, 0, 0, 0, 0, "R7 loop exit");
    drive(1, 4'd8, 0, 0, 0, 0, "R8 manual loop pop");
    drive(1, 4'd8, 0, 0, 0, 0, "R10 loop pop on empty");
    for (int i = 0; i < 4; i++)
      drive(1, 4'd4, 14'(16 * i), 0, 14'(100 + i), 4'(i + 1), "R9 fill loops");
    drive(1, 4'd4, 14'h0777, 0, 14'h0888, 4'hF, "R9 loop push when full");
    for (int i = 0; i < 4; i++)
      drive(1, 4'd5, 0, 0, 0, 0, "R7 unwind");
    drive(1, 4'd5, 0, 0, 0, 0, "R10 exit with empty loop store");
    drive(1, 4'd3, 14'h0123, 0, 0, 0, "R2 irq after loops");
    drive(0, 4'd0, 0, 0, 0, 0, "R11 final idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule